// File: doc/BRIEF.md
# Ordered Supply-Rail Power Sequencer

This block powers up and powers down a group of six regulator rails that feed an attached device. Each rail has an enable output and a power-good input. Rails are brought up one after another, from the lowest supply to the memory supply. Each step waits until the rail reports good, and a timeout limits that wait. After every rail is good, the block raises an aggregate good signal. It then releases the device from reset after a guard time. After a second guard time it reports that the device is powered.

Power-down walks the rails in the reverse order. The device reset is asserted and the aggregate good is dropped before the first rail is disabled. A per-step settle time follows each rail. A rail that fails to come up during power-up is flagged, and the block then runs the complete power-down walk. In that case it never asserts the aggregate good and never releases reset. A rail that fails to go down during power-down is flagged, and the walk carries on with the next rail.

All waits are counted in microseconds, using a tick divided down from the system clock. Power-good inputs are treated as asynchronous.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, every enable pin sits at its inactive level. That level is the pin value of `EN_ACTIVE_LOW` for the rail. `dev_rst_n` and `all_good` are low, and `busy`, `powered_on`, `fault` and `rail_fault` are all zero.
- R2: On power-up, logical enables rise one rail at a time in the order 0,1,2,3,4,5. Rail r+1 is enabled only after rail r's power-good has been seen high through a two-flop synchronizer, which means at least two clock cycles after the input rises.
- R3: Each rail's wait for power-good is abandoned after `PG_TIMEOUT_US` microseconds. The default is 20000.
- R4: Pin `en_out[r]` equals the logical enable XOR `EN_ACTIVE_LOW[r]`. Power-good is always compared with the logical target: high when turning a rail on, low when turning it off.
- R5: When the last rail reports good, `all_good` rises. `dev_rst_n` rises `GUARD_MS` (1 ms) later. `powered_on` rises a further `GUARD_MS` after that.
- R6: A power-up timeout sets that rail's bit in `rail_fault` and starts the full power-down walk. During that attempt `all_good` and `dev_rst_n` stay low. The sequencer ends idle-off with `powered_on` low. `fault` is the OR of `rail_fault`.
- R7: Power-down first drives `dev_rst_n` low and clears `powered_on`. One cycle later it clears `all_good` and disables rail 5. It then disables rails 4,3,2,1,0 in turn, and each waits for power-good to read low.
- R8: After the rails of the power-down walk (5,4,3,2,1,0), the settle times are 0,3,2,4,0,0 ms respectively. The settle time starts once the rail's power-good reads low or its wait times out. No settle time is applied during power-up.
- R9: A power-down timeout sets that rail's bit in `rail_fault`, and the walk continues to the next rail.
- R10: Requests made while `busy` is high are ignored. A power-on request is ignored while powered on, and a power-off request is ignored while idle-off.
- R11: `busy` is high from an accepted request until the sequencer is idle again. `rail_fault` is cleared when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on_req | input | 1 | Power-up request, sampled each cycle |
| pwr_off_req | input | 1 | Power-down request, sampled each cycle |
| pg_in | input | NUM_RAILS | Raw regulator power-good inputs, asynchronous |
| en_out | output | NUM_RAILS | Regulator enable pins, polarity per `EN_ACTIVE_LOW` |
| dev_rst_n | output | 1 | Device reset, active low |
| all_good | output | 1 | All rails good, to the device |
| busy | output | 1 | A sequence is in progress |
| powered_on | output | 1 | Power-up completed and not yet torn down |
| fault | output | 1 | Some rail timed out in the last sequence |
| rail_fault | output | NUM_RAILS | Per-rail timeout flags |

## Verification
The assertions take for granted that requests are single-cycle pulses and that power-good inputs change only as a consequence of the enables. A regulator model in the bench keeps to this: it makes each power-good follow its logical enable after a random latency that is well inside the timeout. Faults are injected only as a rail whose power-good never rises, or one that never falls. Random rounds draw the latency and a single faulty rail from a fixed seed. Directed cases cover polarity, request filtering and the measured guard, settle and timeout windows.

// File: rtl/pwrseq_pkg.sv
// Shared types for the supply-rail sequencer.
// Assumes: one state register, one rail index register.
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_OFF   = 3'd0,
        ST_ON_RAIL    = 3'd1,
        ST_ON_GUARD   = 3'd2,
        ST_ON_HOLD    = 3'd3,
        ST_IDLE_ON    = 3'd4,
        ST_OFF_START  = 3'd5,
        ST_OFF_RAIL   = 3'd6,
        ST_OFF_SETTLE = 3'd7
    } seq_state_e;

endpackage

// File: rtl/pwrseq_us_tick.sv
// Microsecond tick prescaler.
// Emits a one-cycle pulse every CYC_PER_US clocks. It is free-running.
// Assumes: CYC_PER_US >= 1.
module pwrseq_us_tick #(
    parameter int CYC_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CYC_PER_US == 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CYC_PER_US);
            localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);
            logic [CW-1:0] cnt_q;

            // Count clocks and wrap once per microsecond.
            always_ff @(posedge clk) begin
                if (!rst_n)              cnt_q <= '0;
                else if (cnt_q == LAST)  cnt_q <= '0;
                else                     cnt_q <= cnt_q + CW'(1);
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/pwrseq_pg_sync.sv
// Two-flop synchronizer for the power-good inputs, one chain per rail.
// Assumes: inputs are level signals that are slow compared with clk.
module pwrseq_pg_sync #(
    parameter int NUM_RAILS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] pg_raw,
    output logic [NUM_RAILS-1:0] pg_sync
);
    genvar r;
    generate
        for (r = 0; r < NUM_RAILS; r++) begin : g_rail
            logic meta_q, stab_q;

            // Resample the raw power-good twice.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= pg_raw[r];
                    stab_q <= meta_q;
                end
            end

            assign pg_sync[r] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/pwrseq_us_timer.sv
// Saturating microsecond counter with a clear input.
// `expired` is high once the count has reached `limit`. It is masked in the
// cycle in which clear is active.
// Assumes: `limit` stays constant while the FSM stays in a state.
module pwrseq_us_timer #(
    parameter int TW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Restart on clear, otherwise advance on each tick until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)            cnt_q <= '0;
        else if (tick && !(&cnt_q))   cnt_q <= cnt_q + TW'(1);
    end

    assign expired = !clr && (cnt_q >= limit);
endmodule

// File: rtl/pwrseq_ctrl.sv
// Ordered supply-rail power sequencer, top level.
// Brings rails up in the order 0..NUM_RAILS-1, with a power-good wait and timeout
// on each. Then it raises all_good, releases reset and reports powered-on,
// with a guard time between each of these. Tears down in reverse order with
// per-step settle times. A failed power-up falls into the full tear-down.
// Assumes: requests are sampled synchronously and pg_in is asynchronous.
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int                       NUM_RAILS     = 6,
    parameter int                       CYC_PER_US    = 125,
    parameter int                       PG_TIMEOUT_US = 20000,
    parameter int                       US_PER_MS     = 1000,
    parameter int                       GUARD_MS      = 1,
    parameter logic [NUM_RAILS-1:0]     EN_ACTIVE_LOW = '0,
    parameter logic [NUM_RAILS*8-1:0]   OFF_SETTLE_MS = {8'd0, 8'd0, 8'd4, 8'd2, 8'd3, 8'd0}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_on_req,
    input  logic                 pwr_off_req,
    input  logic [NUM_RAILS-1:0] pg_in,
    output logic [NUM_RAILS-1:0] en_out,
    output logic                 dev_rst_n,
    output logic                 all_good,
    output logic                 busy,
    output logic                 powered_on,
    output logic                 fault,
    output logic [NUM_RAILS-1:0] rail_fault
);
    localparam int IDX_W    = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1;
    localparam int GUARD_US = GUARD_MS * US_PER_MS;
    localparam int MAX_US   = (PG_TIMEOUT_US > 255 * US_PER_MS) ? PG_TIMEOUT_US
                            : ((GUARD_US > 255 * US_PER_MS) ? GUARD_US : 255 * US_PER_MS);
    localparam int TW       = $clog2(MAX_US + 1) + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RAILS - 1);

    seq_state_e           state_q;
    logic [IDX_W-1:0]     idx_q;
    logic [NUM_RAILS-1:0] en_log_q;
    logic [NUM_RAILS-1:0] flt_q;
    logic [NUM_RAILS-1:0] pg_s;
    logic                 dev_rst_q, good_q, on_q, clr_q;
    logic                 tick, expired;
    logic [TW-1:0]        limit;
    logic [IDX_W-1:0]     idx_up, idx_dn;
    int                   settle_ms;

    pwrseq_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pwrseq_pg_sync #(.NUM_RAILS(NUM_RAILS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pg_raw(pg_in), .pg_sync(pg_s)
    );

    pwrseq_us_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(clr_q), .tick(tick),
        .limit(limit), .expired(expired)
    );

    assign idx_up = idx_q + IDX_W'(1);
    assign idx_dn = idx_q - IDX_W'(1);

    // Look up the settle time of the current tear-down step (step = last - rail).
    always_comb begin
        settle_ms = 0;
        for (int k = 0; k < NUM_RAILS; k++) begin
            if (idx_q == IDX_W'(k))
                settle_ms = int'(OFF_SETTLE_MS[(NUM_RAILS-1-k)*8 +: 8]);
        end
    end

    // Select the wait length for the current state, in microseconds.
    always_comb begin
        case (state_q)
            ST_ON_RAIL, ST_OFF_RAIL:  limit = TW'(PG_TIMEOUT_US);
            ST_ON_GUARD, ST_ON_HOLD:  limit = TW'(GUARD_US);
            ST_OFF_SETTLE:            limit = TW'(settle_ms * US_PER_MS);
            default:                  limit = '0;
        endcase
    end

    // Main sequencing FSM: rail walk, guard times and the request filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE_OFF;
            idx_q     <= '0;
            en_log_q  <= '0;
            flt_q     <= '0;
            dev_rst_q <= 1'b0;
            good_q    <= 1'b0;
            on_q      <= 1'b0;
            clr_q     <= 1'b1;
        end else begin
            clr_q <= 1'b0;
            case (state_q)
                ST_IDLE_OFF: begin
                    if (pwr_on_req) begin
                        flt_q       <= '0;
                        dev_rst_q   <= 1'b0;
                        idx_q       <= '0;
                        en_log_q[0] <= 1'b1;
                        clr_q       <= 1'b1;
                        state_q     <= ST_ON_RAIL;
                    end
                end
                ST_ON_RAIL: begin
                    if (pg_s[idx_q]) begin
                        clr_q <= 1'b1;
                        if (idx_q == LAST_IDX) begin
                            good_q  <= 1'b1;
                            state_q <= ST_ON_GUARD;
                        end else begin
                            idx_q            <= idx_up;
                            en_log_q[idx_up] <= 1'b1;
                        end
                    end else if (expired) begin
                        flt_q[idx_q] <= 1'b1;
                        state_q      <= ST_OFF_START;
                    end
                end
                ST_ON_GUARD: begin
                    if (expired) begin
                        dev_rst_q <= 1'b1;
                        clr_q     <= 1'b1;
                        state_q   <= ST_ON_HOLD;
                    end
                end
                ST_ON_HOLD: begin
                    if (expired) begin
                        on_q    <= 1'b1;
                        state_q <= ST_IDLE_ON;
                    end
                end
                ST_IDLE_ON: begin
                    if (pwr_off_req) begin
                        flt_q     <= '0;
                        dev_rst_q <= 1'b0;
                        on_q      <= 1'b0;
                        state_q   <= ST_OFF_START;
                    end
                end
                ST_OFF_START: begin
                    good_q             <= 1'b0;
                    idx_q              <= LAST_IDX;
                    en_log_q[LAST_IDX] <= 1'b0;
                    clr_q              <= 1'b1;
                    state_q            <= ST_OFF_RAIL;
                end
                ST_OFF_RAIL: begin
                    if (!pg_s[idx_q] || expired) begin
                        if (pg_s[idx_q]) flt_q[idx_q] <= 1'b1;
                        clr_q   <= 1'b1;
                        state_q <= ST_OFF_SETTLE;
                    end
                end
                ST_OFF_SETTLE: begin
                    if (expired) begin
                        if (idx_q == '0) begin
                            state_q <= ST_IDLE_OFF;
                        end else begin
                            idx_q            <= idx_dn;
                            en_log_q[idx_dn] <= 1'b0;
                            clr_q            <= 1'b1;
                            state_q          <= ST_OFF_RAIL;
                        end
                    end
                end
                default: state_q <= ST_IDLE_OFF;
            endcase
        end
    end

    assign en_out     = en_log_q ^ EN_ACTIVE_LOW;
    assign dev_rst_n  = dev_rst_q;
    assign all_good   = good_q;
    assign powered_on = on_q;
    assign rail_fault = flt_q;
    assign fault      = |flt_q;
    assign busy       = (state_q != ST_IDLE_OFF) && (state_q != ST_IDLE_ON);
endmodule

// File: rtl/pwrseq_chk.sv
// Port-level property checker for pwrseq_ctrl, attached with bind.
// Assumes: the checker sees the same parameters as the instance it is bound to.
module pwrseq_chk #(
    parameter int                   NUM_RAILS     = 6,
    parameter logic [NUM_RAILS-1:0] EN_ACTIVE_LOW = '0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RAILS-1:0] en_out,
    input logic                 dev_rst_n,
    input logic                 all_good,
    input logic                 busy,
    input logic                 powered_on,
    input logic                 fault
);
    logic [NUM_RAILS-1:0] en_l;
    assign en_l = en_out ^ EN_ACTIVE_LOW;

    AST_ONE_RAIL_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(en_l ^ $past(en_l)) <= 1); // R2

    AST_GOOD_AFTER_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_good) |-> (&en_l)); // R5

    AST_RELEASE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst_n |-> all_good); // R5

    AST_RESET_BEFORE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(all_good) |-> (!dev_rst_n && $past(!dev_rst_n))); // R7

    AST_IDLE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !powered_on) |-> (en_l == '0 && !all_good && !dev_rst_n)); // R6

    AST_ON_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        powered_on |-> ((&en_l) && dev_rst_n && all_good && !busy)); // R5

    AST_FAULT_NOT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !powered_on); // R6
endmodule

bind pwrseq_ctrl pwrseq_chk #(
    .NUM_RAILS(NUM_RAILS), .EN_ACTIVE_LOW(EN_ACTIVE_LOW)
) u_pwrseq_chk (
    .clk(clk), .rst_n(rst_n), .en_out(en_out), .dev_rst_n(dev_rst_n),
    .all_good(all_good), .busy(busy), .powered_on(powered_on), .fault(fault)
);

// File: tb/test_pwrseq_ctrl.sv
// Self-checking bench for pwrseq_ctrl with a behavioural regulator model.
module test_pwrseq_ctrl;
    localparam int N  = 6;
    localparam int C  = 2;    // clocks per microsecond
    localparam int TO = 20;   // timeout, us
    localparam int L  = 4;    // microseconds per ms
    localparam logic [N-1:0] POL = 6'b000100;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on_req = 1'b0, pwr_off_req = 1'b0;
    logic [N-1:0] pg_in = '0;
    logic [N-1:0] en_out, rail_fault;
    logic dev_rst_n, all_good, busy, powered_on, fault;

    always #4 clk = ~clk;

    pwrseq_ctrl #(
        .NUM_RAILS(N), .CYC_PER_US(C), .PG_TIMEOUT_US(TO), .US_PER_MS(L),
        .GUARD_MS(1), .EN_ACTIVE_LOW(POL)
    ) i_pwrseq_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .pg_in(pg_in), .en_out(en_out), .dev_rst_n(dev_rst_n), .all_good(all_good),
        .busy(busy), .powered_on(powered_on), .fault(fault), .rail_fault(rail_fault)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int lat = 3;
    logic [N-1:0] dead = '0, stuck = '0;
    int cnt [N];
    int en_rise_t [N], en_fall_t [N], pg_rise_t [N], pg_fall_t [N];
    int rise_order [N];
    int n_rise = 0;
    int good_rise_t, good_fall_t, rst_rise_t, rst_fall_t, on_rise_t;
    logic ever_good = 1'b0, ever_rel = 1'b0;
    logic [N-1:0] prev_en = '0, prev_pg = '0;
    logic prev_good = 1'b0, prev_rst = 1'b0, prev_on = 1'b0;

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int settle_of_step(input int s);
        case (s)
            1: return 3;
            2: return 2;
            3: return 4;
            default: return 0;
        endcase
    endfunction

    // Monitor first, then the regulator model, once per falling edge.
    always @(negedge clk) begin
        logic [N-1:0] el;
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
        el = en_out ^ POL;
        for (int r = 0; r < N; r++) begin
            if (el[r] && !prev_en[r]) begin
                en_rise_t[r] = cyc;
                if (n_rise < N) rise_order[n_rise] = r;
                n_rise++;
            end
            if (!el[r] && prev_en[r]) en_fall_t[r] = cyc;
            if (pg_in[r] && !prev_pg[r]) pg_rise_t[r] = cyc;
            if (!pg_in[r] && prev_pg[r]) pg_fall_t[r] = cyc;
        end
        if (all_good && !prev_good) begin good_rise_t = cyc; ever_good = 1'b1; end
        if (!all_good && prev_good) good_fall_t = cyc;
        if (dev_rst_n && !prev_rst) begin rst_rise_t = cyc; ever_rel = 1'b1; end
        if (!dev_rst_n && prev_rst) rst_fall_t = cyc;
        if (powered_on && !prev_on) on_rise_t = cyc;
        prev_en = el; prev_pg = pg_in;
        prev_good = all_good; prev_rst = dev_rst_n; prev_on = powered_on;
        for (int r = 0; r < N; r++) begin
            if (el[r] == pg_in[r] || (el[r] && dead[r]) || (!el[r] && stuck[r])) begin
                cnt[r] = 0;
            end else if (cnt[r] >= lat) begin
                pg_in[r] = el[r];
                cnt[r] = 0;
            end else begin
                cnt[r]++;
            end
        end
    end

    task automatic clear_log();
        n_rise = 0;
        ever_good = 1'b0;
        ever_rel = 1'b0;
        for (int r = 0; r < N; r++) begin
            en_rise_t[r] = 0; en_fall_t[r] = 0; pg_rise_t[r] = 0; pg_fall_t[r] = 0;
        end
    endtask

    task automatic pulse(input bit on);
        @(negedge clk);
        if (on) pwr_on_req = 1'b1; else pwr_off_req = 1'b1;
        @(negedge clk);
        pwr_on_req = 1'b0;
        pwr_off_req = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Checks after a clean power-up: order, gating, polarity and guard windows.
    task automatic check_on_ok();
        for (int k = 0; k < N; k++)
            check(rise_order[k] == k, "R2 order", rise_order[k], k);
        for (int r = 0; r + 1 < N; r++)
            check(en_rise_t[r+1] - pg_rise_t[r] >= 2, "R2 gating", en_rise_t[r+1] - pg_rise_t[r], 2);
        check(en_out == ~POL, "R4 pins on", int'(en_out), int'(~POL));
        check(rst_rise_t - good_rise_t >= (L-1)*C+2 && rst_rise_t - good_rise_t <= L*C+3,
              "R5 reset guard", rst_rise_t - good_rise_t, L*C);
        check(on_rise_t - rst_rise_t >= (L-1)*C+2 && on_rise_t - rst_rise_t <= L*C+3,
              "R5 on guard", on_rise_t - rst_rise_t, L*C);
        check(powered_on && dev_rst_n && all_good && !fault, "R5 on state",
              {powered_on, dev_rst_n, all_good, fault}, 4'b1110);
    endtask

    // Checks after a power-down: ordering of reset, good, rails and settles.
    task automatic check_off(input logic [N-1:0] exp_flt);
        int d, lo, hi, gap;
        check(good_fall_t == rst_fall_t + 1, "R7 reset then good", good_fall_t - rst_fall_t, 1);
        check(en_fall_t[N-1] == good_fall_t, "R7 first rail", en_fall_t[N-1], good_fall_t);
        for (int r = N - 1; r > 0; r--) begin
            check(en_fall_t[r-1] > en_fall_t[r], "R7 reverse order", en_fall_t[r-1], en_fall_t[r]);
            if (!exp_flt[r]) begin
                d = settle_of_step(N - 1 - r) * L;
                lo = 3 + ((d > 0) ? (d - 1) * C + 1 : 0);
                hi = 5 + d * C;
                gap = en_fall_t[r-1] - pg_fall_t[r];
                check(gap >= lo && gap <= hi, "R8 settle", gap, d * C);
            end
        end
        check(rail_fault == exp_flt, "R9 flags", int'(rail_fault), int'(exp_flt));
        check(en_out == POL && !powered_on && !dev_rst_n && !all_good && !busy, "R7 end state",
              int'(en_out), int'(POL));
    endtask

    initial begin
        logic [N-1:0] pins;
        logic [N-1:0] mask;
        int gap;
        void'($urandom(32'd12345));
        for (int r = 0; r < N; r++) cnt[r] = 0;
        repeat (4) @(negedge clk);
        check(en_out == POL, "R1 enables", int'(en_out), int'(POL));
        check(!dev_rst_n && !all_good && !busy && !powered_on && !fault && rail_fault == '0,
              "R1 status", {dev_rst_n, all_good, busy, powered_on, fault}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: power-off request while idle-off has no effect.
        pulse(1'b0);
        repeat (4) @(negedge clk);
        check(!busy && en_out == POL, "R10 off while off", int'(en_out), int'(POL));

        // Clean power-up with busy observed mid-sequence.
        clear_log();
        pulse(1'b1);
        repeat (2) @(negedge clk);
        check(busy, "R11 busy", busy, 1);
        wait_idle();
        check_on_ok();

        // R10: power-on request while powered on has no effect.
        pins = en_out;
        pulse(1'b1);
        repeat (4) @(negedge clk);
        check(!busy && powered_on && en_out == pins, "R10 on while on", int'(en_out), int'(pins));

        // Clean power-down.
        clear_log();
        pulse(1'b0);
        wait_idle();
        check_off('0);

        // R10: power-off request during power-up is dropped.
        clear_log();
        pulse(1'b1);
        repeat (3) @(negedge clk);
        pulse(1'b0);
        wait_idle();
        check(powered_on && en_out == ~POL, "R10 off during on", powered_on, 1);
        clear_log();
        pulse(1'b0);
        wait_idle();

        // R6: rail 3 never comes up.
        clear_log();
        dead = 6'b001000;
        pulse(1'b1);
        wait_idle();
        check(rail_fault == 6'b001000 && fault, "R6 flag", int'(rail_fault), 8);
        check(!ever_good && !ever_rel, "R6 no release", {ever_good, ever_rel}, 0);
        check(en_out == POL && !powered_on, "R6 torn down", int'(en_out), int'(POL));
        check(n_rise == 4, "R6 rails tried", n_rise, 4);
        dead = '0;

        // R11: flags clear when the next request is accepted.
        clear_log();
        pulse(1'b1);
        wait_idle();
        check(rail_fault == '0 && !fault, "R11 flags cleared", int'(rail_fault), 0);
        check_on_ok();

        // R9 and R3: rail 5 never goes down; timeout, then walk continues.
        clear_log();
        stuck = 6'b100000;
        pulse(1'b0);
        wait_idle();
        check_off(6'b100000);
        gap = en_fall_t[4] - en_fall_t[5];
        check(gap >= (TO-1)*C+3 && gap <= TO*C+5, "R3 timeout", gap, TO*C);
        stuck = '0;
        repeat (10) @(negedge clk);

        // Random rounds: latency and a single faulty rail drawn from the seed.
        for (int round = 0; round < 16; round++) begin
            lat = $urandom_range(1, 6);
            mask = '0;
            if ($urandom_range(0, 2) == 0) mask[$urandom_range(0, N-1)] = 1'b1;
            dead = mask;
            clear_log();
            pulse(1'b1);
            wait_idle();
            dead = '0;
            if (mask != '0) begin
                check(rail_fault == mask && !powered_on && !ever_rel, "R6 random",
                      int'(rail_fault), int'(mask));
                repeat (10) @(negedge clk);
            end else begin
                check_on_ok();
                mask = '0;
                if ($urandom_range(0, 2) == 0) mask[$urandom_range(0, N-1)] = 1'b1;
                stuck = mask;
                clear_log();
                pulse(1'b0);
                wait_idle();
                check_off(mask);
                stuck = '0;
                repeat (10) @(negedge clk);
            end
        end

        summary();
        $finish;
    end
endmodule